// File: doc/BRIEF.md
# Video Mode Table Matcher

This block keeps a small table of programmable video modes. Each entry holds an active width, an active height and an interlace flag, plus a valid bit. A resolution measurement arrives as a one-cycle strobe with its width, height and interlace values. The block compares it against the committed settings of every valid mode, records the index of the winning mode in a match register, and drives the committed settings of that mode on its active outputs.

Software reaches the table through a simple word-addressed register bus. To reprogram a mode, it first clears the mode's valid bit, then writes the staged fields, then sets the valid bit again. Only that last write moves the staged fields into the committed copy that is used for matching and output. The staged fields can be split into banks, and a bank-select register picks the bank that writes, readback and commits use. This allows a mode to be rewritten while it is selected without any glitch on the outputs.

A single interrupt line merges two sticky sources, each with its own enable. One source is a status event, raised when a measurement changes the match register. The other is a lock event, raised when the outgoing start-of-frame becomes aligned with the incoming one.

Top module: `vmode_matcher`

## Requirements
- R1: After synchronous reset the match register reads all ones (7 with four modes), the control, flag and bank registers read 0, `irq` and `gen_locked` are 0, and the active outputs are 0.
- R2: Word addresses are: 0 control, 1 match (read only), 2 flags, 3 bank select (bit 0), and mode k at 8+4k with offset 0 width, 1 height, 2 interlace (bit 0) and 3 valid (bit 0). Read data appears on `bus_rdata` at the clock edge after the address is presented. The match register changes only at the edge that samples `meas_stb` high.
- R3: When several valid modes match a measurement on width, height and interlace, the lowest-numbered one is recorded.
- R4: Writes to a mode's width, height and interlace fields are staged only. Writing 1 to the valid field copies the staged fields of the selected bank into the committed settings and makes the mode eligible for matching.
- R5: Writing 0 to a valid field removes the mode from matching. Its fields read back unchanged.
- R6: Field writes, field readback and commits use the bank named by the bank-select register.
- R7: The active outputs show the committed settings of the matched mode one edge after the match register or those settings change. Clearing the valid bit of the selected mode and restaging its fields leaves the outputs unchanged.
- R8: If no valid mode matches, the match register holds the all-ones code.
- R9: The status flag (flag bit 1) is set at the edge where a measurement changes the match register value, including a change to the no-match code. A measurement that leaves the value unchanged does not set it.
- R10: When `sof_in` and `sof_out` pulse in the same cycle while the block is not locked, `gen_locked` rises and the lock flag (flag bit 2) is set. A pulse on only one of them clears `gen_locked`.
- R11: Writing 1 to a flag bit clears that flag. Writing 0 to it has no effect.
- R12: If a flag is set and cleared in the same cycle, it stays set.
- R13: `irq` is registered and equals the OR of the flags ANDed with the enables in control bits [2:1]. It changes at the same edge as the flags or the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Registered read data |
| meas_stb | input | 1 | Measurement valid strobe |
| meas_width | input | RES_W | Measured active width |
| meas_height | input | RES_W | Measured active height |
| meas_interlace | input | 1 | Measured interlace flag |
| sof_in | input | 1 | Incoming start-of-frame pulse |
| sof_out | input | 1 | Outgoing start-of-frame pulse |
| active_width | output | RES_W | Committed width of matched mode |
| active_height | output | RES_W | Committed height of matched mode |
| active_interlace | output | 1 | Committed interlace of matched mode |
| gen_locked | output | 1 | Frame starts currently aligned |
| irq | output | 1 | Merged interrupt |

## Verification
The bench uses the default parameters: four modes, two staging banks and 16-bit resolution fields. Four modes are enough to have two or three valid entries match the same measurement, so the priority order can be tested, and they leave the no-match code 7 distinct from every index. Two banks let the bench stage different values in each bank for the same mode and see which bank a commit takes. The random phase draws resolutions from a small set so that overlaps, re-matches of the same index and changes to no-match all occur often.

// File: rtl/vmode_pkg.sv
package vmode_pkg;
  localparam int unsigned REG_CTRL    = 0;
  localparam int unsigned REG_MATCH   = 1;
  localparam int unsigned REG_FLAGS   = 2;
  localparam int unsigned REG_BANK    = 3;
  localparam int unsigned MODE_BASE   = 8;
  localparam int unsigned MODE_STRIDE = 4;
  localparam int unsigned IRQ_LSB     = 1;
  localparam int unsigned IRQ_SRCS    = 2;

  typedef enum logic [1:0] {
    FLD_WIDTH  = 2'd0,
    FLD_HEIGHT = 2'd1,
    FLD_ILACE  = 2'd2,
    FLD_VALID  = 2'd3
  } mode_field_e;
endpackage

// File: rtl/vmode_table.sv
module vmode_table
  import vmode_pkg::*;
#(
  parameter int NUM_MODES = 4,
  parameter int NUM_BANKS = 2,
  parameter int RES_W     = 16,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [((NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1)-1:0] bank_sel,
  output logic              in_tbl,
  output logic [DATA_W-1:0] rd_data,
  output logic [RES_W-1:0]  act_w [NUM_MODES],
  output logic [RES_W-1:0]  act_h [NUM_MODES],
  output logic [NUM_MODES-1:0] act_i,
  output logic [NUM_MODES-1:0] mode_valid
);
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int IDX_W  = (NUM_MODES > 1) ? $clog2(NUM_MODES) : 1;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(MODE_BASE);
  localparam logic [ADDR_W-1:0] END_A  = ADDR_W'(MODE_BASE + NUM_MODES * MODE_STRIDE);

  logic [ADDR_W-1:0] off;
  logic [IDX_W-1:0]  mode_idx;
  mode_field_e       fld;
  logic [BANK_W-1:0] eff_bank;
  logic [DATA_W-1:0] rd_word [NUM_MODES];
  logic [DATA_W-RES_W-1:0] unused_wdata_hi;

  assign off      = addr - BASE_A;
  assign in_tbl   = (addr >= BASE_A) && (addr < END_A);
  assign mode_idx = off[IDX_W+1:2];
  assign fld      = mode_field_e'(off[1:0]);
  assign unused_wdata_hi = wdata[DATA_W-1:RES_W];

  generate
    if (NUM_BANKS > 1) begin : g_banked
      assign eff_bank = bank_sel;
    end else begin : g_flat
      logic unused_bank;
      assign unused_bank = ^bank_sel;
      assign eff_bank    = '0;
    end
  endgenerate

  generate
    for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
      logic [RES_W-1:0] stg_w [NUM_BANKS];
      logic [RES_W-1:0] stg_h [NUM_BANKS];
      logic [NUM_BANKS-1:0] stg_i;
      logic [RES_W-1:0] com_w, com_h;
      logic             com_i, vld;
      logic             sel;

      assign sel = wr_en && in_tbl && (mode_idx == IDX_W'(m));

      always_ff @(posedge clk) begin
        if (rst) begin
          for (int b = 0; b < NUM_BANKS; b++) begin
            stg_w[b] <= '0;
            stg_h[b] <= '0;
          end
          stg_i <= '0;
          com_w <= '0;
          com_h <= '0;
          com_i <= 1'b0;
          vld   <= 1'b0;
        end else if (sel) begin
          case (fld)
            FLD_WIDTH:  stg_w[eff_bank] <= wdata[RES_W-1:0];
            FLD_HEIGHT: stg_h[eff_bank] <= wdata[RES_W-1:0];
            FLD_ILACE:  stg_i[eff_bank] <= wdata[0];
            default: begin
              vld <= wdata[0];
              if (wdata[0]) begin
                com_w <= stg_w[eff_bank];
                com_h <= stg_h[eff_bank];
                com_i <= stg_i[eff_bank];
              end
            end
          endcase
        end
      end

      always_comb begin
        case (fld)
          FLD_WIDTH:  rd_word[m] = DATA_W'(stg_w[eff_bank]);
          FLD_HEIGHT: rd_word[m] = DATA_W'(stg_h[eff_bank]);
          FLD_ILACE:  rd_word[m] = DATA_W'(stg_i[eff_bank]);
          default:    rd_word[m] = DATA_W'(vld);
        endcase
      end

      assign act_w[m]      = com_w;
      assign act_h[m]      = com_h;
      assign act_i[m]      = com_i;
      assign mode_valid[m] = vld;
    end
  endgenerate

  assign rd_data = in_tbl ? rd_word[mode_idx] : '0;
endmodule

// File: rtl/vmode_match_sel.sv
module vmode_match_sel #(
  parameter int NUM_MODES = 4,
  parameter int RES_W     = 16,
  parameter int MATCH_W   = 3
) (
  input  logic [RES_W-1:0]     meas_w,
  input  logic [RES_W-1:0]     meas_h,
  input  logic                 meas_i,
  input  logic [RES_W-1:0]     act_w [NUM_MODES],
  input  logic [RES_W-1:0]     act_h [NUM_MODES],
  input  logic [NUM_MODES-1:0] act_i,
  input  logic [NUM_MODES-1:0] mode_valid,
  output logic [MATCH_W-1:0]   hit_idx
);
  logic [NUM_MODES-1:0] eq;

  generate
    for (genvar m = 0; m < NUM_MODES; m++) begin : g_cmp
      assign eq[m] = mode_valid[m] && (act_w[m] == meas_w) &&
                     (act_h[m] == meas_h) && (act_i[m] == meas_i);
    end
  endgenerate

  always_comb begin
    hit_idx = '1;
    for (int m = NUM_MODES - 1; m >= 0; m--) begin
      if (eq[m]) hit_idx = MATCH_W'(m);
    end
  end
endmodule

// File: rtl/vmode_lock_det.sv
module vmode_lock_det (
  input  logic clk,
  input  logic rst,
  input  logic sof_in,
  input  logic sof_out,
  output logic locked_q,
  output logic lock_evt
);
  assign lock_evt = sof_in && sof_out && !locked_q;

  always_ff @(posedge clk) begin
    if (rst) locked_q <= 1'b0;
    else if (sof_in || sof_out) locked_q <= sof_in && sof_out;
  end
endmodule

// File: rtl/vmode_irq.sv
module vmode_irq #(
  parameter int NUM_SRC = 2,
  parameter int LSB     = 1,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ctrl_wr,
  input  logic               flags_wr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_SRC-1:0] set_evt,
  output logic [NUM_SRC-1:0] en_q,
  output logic [NUM_SRC-1:0] flags_q,
  output logic               irq_q
);
  logic [NUM_SRC-1:0] en_nxt, clr, fl_nxt;

  always_comb begin
    en_nxt = ctrl_wr  ? wdata[LSB +: NUM_SRC] : en_q;
    clr    = flags_wr ? wdata[LSB +: NUM_SRC] : '0;
    fl_nxt = (flags_q & ~clr) | set_evt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      en_q    <= en_nxt;
      flags_q <= fl_nxt;
      irq_q   <= |(fl_nxt & en_nxt);
    end
  end
endmodule

// File: rtl/vmode_matcher.sv
module vmode_matcher
  import vmode_pkg::*;
#(
  parameter int NUM_MODES = 4,
  parameter int NUM_BANKS = 2,
  parameter int RES_W     = 16,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              meas_stb,
  input  logic [RES_W-1:0]  meas_width,
  input  logic [RES_W-1:0]  meas_height,
  input  logic              meas_interlace,
  input  logic              sof_in,
  input  logic              sof_out,
  output logic [RES_W-1:0]  active_width,
  output logic [RES_W-1:0]  active_height,
  output logic              active_interlace,
  output logic              gen_locked,
  output logic              irq
);
  localparam int IDX_W   = (NUM_MODES > 1) ? $clog2(NUM_MODES) : 1;
  localparam int MATCH_W = IDX_W + 1;
  localparam int BANK_W  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic [BANK_W-1:0]    bank_q;
  logic [MATCH_W-1:0]   match_q, hit_idx;
  logic                 tbl_hit;
  logic [DATA_W-1:0]    tbl_rdata, rd_nxt;
  logic [RES_W-1:0]     act_w [NUM_MODES];
  logic [RES_W-1:0]     act_h [NUM_MODES];
  logic [NUM_MODES-1:0] act_i, mode_valid;
  logic [IRQ_SRCS-1:0]  en_q, flags_q;
  logic                 status_set, lock_evt;
  logic                 ctrl_wr, flags_wr, bank_wr;
  logic                 found;
  logic [IDX_W-1:0]     sel_idx;

  assign ctrl_wr  = bus_wr && (bus_addr == ADDR_W'(REG_CTRL));
  assign flags_wr = bus_wr && (bus_addr == ADDR_W'(REG_FLAGS));
  assign bank_wr  = bus_wr && (bus_addr == ADDR_W'(REG_BANK));

  vmode_table #(
    .NUM_MODES(NUM_MODES), .NUM_BANKS(NUM_BANKS), .RES_W(RES_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_table (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .bank_sel(bank_q), .in_tbl(tbl_hit), .rd_data(tbl_rdata),
    .act_w(act_w), .act_h(act_h), .act_i(act_i), .mode_valid(mode_valid)
  );

  vmode_match_sel #(
    .NUM_MODES(NUM_MODES), .RES_W(RES_W), .MATCH_W(MATCH_W)
  ) u_sel (
    .meas_w(meas_width), .meas_h(meas_height), .meas_i(meas_interlace),
    .act_w(act_w), .act_h(act_h), .act_i(act_i), .mode_valid(mode_valid),
    .hit_idx(hit_idx)
  );

  vmode_lock_det u_lock (
    .clk(clk), .rst(rst), .sof_in(sof_in), .sof_out(sof_out),
    .locked_q(gen_locked), .lock_evt(lock_evt)
  );

  assign status_set = meas_stb && (hit_idx != match_q);

  vmode_irq #(
    .NUM_SRC(IRQ_SRCS), .LSB(IRQ_LSB), .DATA_W(DATA_W)
  ) u_irq (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .flags_wr(flags_wr),
    .wdata(bus_wdata), .set_evt({lock_evt, status_set}),
    .en_q(en_q), .flags_q(flags_q), .irq_q(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= '1;
      bank_q  <= '0;
    end else begin
      if (meas_stb) match_q <= hit_idx;
      if (bank_wr)  bank_q  <= bus_wdata[BANK_W-1:0];
    end
  end

  assign found   = ~&match_q;
  assign sel_idx = match_q[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || !found) begin
      active_width     <= '0;
      active_height    <= '0;
      active_interlace <= 1'b0;
    end else begin
      active_width     <= act_w[sel_idx];
      active_height    <= act_h[sel_idx];
      active_interlace <= act_i[sel_idx];
    end
  end

  always_comb begin
    rd_nxt = '0;
    if (tbl_hit) begin
      rd_nxt = tbl_rdata;
    end else begin
      case (bus_addr)
        ADDR_W'(REG_CTRL):  rd_nxt[IRQ_LSB +: IRQ_SRCS] = en_q;
        ADDR_W'(REG_MATCH): rd_nxt[MATCH_W-1:0] = match_q;
        ADDR_W'(REG_FLAGS): rd_nxt[IRQ_LSB +: IRQ_SRCS] = flags_q;
        ADDR_W'(REG_BANK):  rd_nxt[BANK_W-1:0] = bank_q;
        default:            rd_nxt = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_nxt;
  end
endmodule

// File: rtl/vmode_checker.sv
module vmode_checker #(
  parameter int NUM_MODES = 4,
  parameter int IDX_W     = 2,
  parameter int MATCH_W   = 3,
  parameter int DATA_W    = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               meas_stb,
  input logic [MATCH_W-1:0] match_q,
  input logic [MATCH_W-1:0] hit_idx,
  input logic [NUM_MODES-1:0] mode_valid,
  input logic [1:0]         flags_q,
  input logic [1:0]         en_q,
  input logic               irq,
  input logic               gen_locked,
  input logic               status_set,
  input logic               flags_wr,
  input logic [DATA_W-1:0]  bus_wdata
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (match_q == '1 && flags_q == 2'b00 && !irq && !gen_locked));

  a_r2_match_only_on_strobe: assert property (@(posedge clk) disable iff (rst)
    !$past(meas_stb) |-> $stable(match_q));

  a_r5_hit_is_valid: assert property (@(posedge clk) disable iff (rst)
    (hit_idx != '1) |-> mode_valid[hit_idx[IDX_W-1:0]]);

  a_r8_code_range: assert property (@(posedge clk) disable iff (rst)
    (match_q == '1) || (int'(match_q) < NUM_MODES));

  a_r9_status_on_change: assert property (@(posedge clk) disable iff (rst)
    (match_q != $past(match_q)) |-> flags_q[0]);

  a_r10_lock_flag: assert property (@(posedge clk) disable iff (rst)
    $rose(gen_locked) |-> flags_q[1]);

  a_r11_w1c_status: assert property (@(posedge clk) disable iff (rst)
    (flags_wr && bus_wdata[1] && !status_set) |=> !flags_q[0]);

  a_r13_irq_merge: assert property (@(posedge clk) disable iff (rst)
    irq == |(flags_q & en_q));
endmodule

bind vmode_matcher vmode_checker #(
  .NUM_MODES(NUM_MODES), .IDX_W(IDX_W), .MATCH_W(MATCH_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .meas_stb(meas_stb), .match_q(match_q),
  .hit_idx(hit_idx), .mode_valid(mode_valid), .flags_q(flags_q),
  .en_q(en_q), .irq(irq), .gen_locked(gen_locked), .status_set(status_set),
  .flags_wr(flags_wr), .bus_wdata(bus_wdata)
);

// File: tb/vmode_matcher_tb.sv
module vmode_matcher_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        meas_stb = 1'b0;
  logic [15:0] meas_width = '0, meas_height = '0;
  logic        meas_interlace = 1'b0;
  logic        sof_in = 1'b0, sof_out = 1'b0;
  logic [15:0] active_width, active_height;
  logic        active_interlace, gen_locked, irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int unsigned sh_w[4][2], sh_h[4][2];
  bit          sh_i[4][2];
  int unsigned ac_w[4], ac_h[4];
  bit          ac_i[4], vld[4];
  int          bank = 0;
  int          exp_match = 7;
  bit [2:0]    exp_fl = '0, exp_en = '0;
  bit          m_locked = 0;

  always #10 clk = ~clk;

  vmode_matcher u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .meas_stb(meas_stb),
    .meas_width(meas_width), .meas_height(meas_height),
    .meas_interlace(meas_interlace), .sof_in(sof_in), .sof_out(sof_out),
    .active_width(active_width), .active_height(active_height),
    .active_interlace(active_interlace), .gen_locked(gen_locked), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int predict(int w, int h, bit i);
    for (int m = 0; m < 4; m++)
      if (vld[m] && ac_w[m] == w && ac_h[m] == h && ac_i[m] == i) return m;
    return 7;
  endfunction

  function automatic int exp_read(int a);
    int m, f;
    if (a == 0) return int'(exp_en & 3'b110);
    if (a == 1) return exp_match;
    if (a == 2) return int'(exp_fl & 3'b110);
    if (a == 3) return bank;
    if (a < 8 || a > 23) return 0;
    m = (a - 8) / 4; f = (a - 8) % 4;
    case (f)
      0: return int'(sh_w[m][bank]);
      1: return int'(sh_h[m][bank]);
      2: return int'(sh_i[m][bank]);
      default: return int'(vld[m]);
    endcase
  endfunction

  function automatic void model_wr(int a, int d);
    int m, f;
    if (a == 0) exp_en = d[2:0] & 3'b110;
    else if (a == 2) exp_fl = exp_fl & ~(d[2:0] & 3'b110);
    else if (a == 3) bank = d & 1;
    else if (a >= 8 && a <= 23) begin
      m = (a - 8) / 4; f = (a - 8) % 4;
      case (f)
        0: sh_w[m][bank] = d & 16'hFFFF;
        1: sh_h[m][bank] = d & 16'hFFFF;
        2: sh_i[m][bank] = d[0];
        default: begin
          vld[m] = d[0];
          if (d[0]) begin
            ac_w[m] = sh_w[m][bank]; ac_h[m] = sh_h[m][bank]; ac_i[m] = sh_i[m][bank];
          end
        end
      endcase
    end
  endfunction

  function automatic void model_meas(int w, int h, bit i);
    int p;
    p = predict(w, h, i);
    if (p != exp_match) exp_fl[1] = 1'b1;
    exp_match = p;
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a[5:0]; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    model_wr(a, d);
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    bus_addr = a[5:0];
    @(negedge clk);
    v = int'(bus_rdata);
  endtask

  task automatic meas(input int w, input int h, input bit i);
    @(negedge clk);
    meas_stb = 1'b1; meas_width = w[15:0]; meas_height = h[15:0]; meas_interlace = i;
    @(negedge clk);
    meas_stb = 1'b0;
    model_meas(w, h, i);
  endtask

  task automatic sof(input bit a, input bit b);
    @(negedge clk);
    sof_in = a; sof_out = b;
    @(negedge clk);
    sof_in = 1'b0; sof_out = 1'b0;
    if (a || b) begin
      if (a && b && !m_locked) exp_fl[2] = 1'b1;
      m_locked = a && b;
    end
  endtask

  task automatic chk_reg(input string req, input int a);
    int v;
    rd(a, v);
    chk(req, v, exp_read(a));
  endtask

  task automatic chk_outputs(input string req);
    @(negedge clk);
    chk({req, " width"}, active_width, (exp_match == 7) ? 0 : int'(ac_w[exp_match]));
    chk({req, " height"}, active_height, (exp_match == 7) ? 0 : int'(ac_h[exp_match]));
    chk({req, " ilace"}, active_interlace, (exp_match == 7) ? 0 : int'(ac_i[exp_match]));
  endtask

  function automatic int pick_w();
    int t = $urandom % 4;
    return (t == 0) ? 640 : (t == 1) ? 720 : (t == 2) ? 1280 : 1920;
  endfunction

  function automatic int pick_h();
    int t = $urandom % 3;
    return (t == 0) ? 480 : (t == 1) ? 576 : 720;
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v;
    void'($urandom(32'd20240607));
    for (int m = 0; m < 4; m++) begin
      ac_w[m] = 0; ac_h[m] = 0; ac_i[m] = 0; vld[m] = 0;
      for (int b = 0; b < 2; b++) begin sh_w[m][b] = 0; sh_h[m][b] = 0; sh_i[m][b] = 0; end
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(1, v); chk("R1 match reset", v, 7);
    rd(2, v); chk("R1 flags reset", v, 0);
    rd(0, v); chk("R1 ctrl reset", v, 0);
    chk("R1 irq reset", irq, 0);
    chk("R1 locked reset", gen_locked, 0);
    chk("R1 width reset", active_width, 0);

    // R4 staged fields do not match before commit
    wr(12, 1280); wr(13, 720); wr(14, 0);
    meas(1280, 720, 0);
    rd(1, v); chk("R4 staged only", v, 7);
    wr(15, 1);
    wr(16, 1280); wr(17, 720); wr(18, 0); wr(19, 1);

    // R3 lowest index, R9 status flag, R13 gated irq
    meas(1280, 720, 0);
    rd(1, v); chk("R3 lowest wins", v, 1);
    rd(2, v); chk("R9 status set", v, 2);
    chk("R13 irq masked", irq, 0);
    wr(0, 6);
    chk("R13 irq enabled", irq, 1);
    wr(2, 2);
    rd(2, v); chk("R11 w1c", v, 0);
    chk("R13 irq after clear", irq, 0);
    meas(1280, 720, 0);
    rd(2, v); chk("R9 same match no flag", v, 0);

    // R5 invalidate keeps fields
    wr(15, 0);
    rd(12, v); chk("R5 field kept", v, 1280);
    rd(15, v); chk("R5 valid read", v, 0);
    meas(1280, 720, 0);
    rd(1, v); chk("R5 next mode", v, 2);
    chk_outputs("R7 follow match");

    // R7 hold during reconfigure
    wr(19, 0); wr(16, 1920);
    @(negedge clk);
    chk("R7 held width", active_width, 1280);
    wr(19, 1);
    @(negedge clk);
    chk("R7 commit width", active_width, 1920);

    // R8 no-match code
    wr(2, 6);
    meas(1280, 720, 0);
    rd(1, v); chk("R8 no match", v, 7);
    rd(2, v); chk("R8 R9 flag on no match", v, 2);
    chk_outputs("R8 outputs cleared");

    // R6 banks
    wr(3, 1); wr(8, 720);
    rd(8, v); chk("R6 bank1 readback", v, 720);
    wr(3, 0);
    rd(8, v); chk("R6 bank0 untouched", v, 0);
    wr(3, 1); wr(9, 576); wr(10, 1); wr(11, 1);
    meas(720, 576, 1);
    rd(1, v); chk("R6 commit from bank1", v, 0);
    chk_outputs("R6 outputs");

    // R12 set beats clear
    wr(2, 6);
    @(negedge clk);
    meas_stb = 1'b1; meas_width = 16'd1920; meas_height = 16'd720; meas_interlace = 1'b0;
    bus_wr = 1'b1; bus_addr = 6'd2; bus_wdata = 32'd2;
    @(negedge clk);
    meas_stb = 1'b0; bus_wr = 1'b0;
    model_wr(2, 2); model_meas(1920, 720, 0);
    rd(2, v); chk("R12 set wins", v, 2);
    rd(1, v); chk("R12 match", v, 2);

    // R10 lock
    wr(2, 6);
    sof(1, 1);
    chk("R10 locked", gen_locked, 1);
    rd(2, v); chk("R10 lock flag", v, 4);
    wr(2, 4);
    sof(1, 1);
    rd(2, v); chk("R10 no repeat", v, 0);
    sof(1, 0);
    chk("R10 unlocked", gen_locked, 0);
    sof(1, 1);
    rd(2, v); chk("R10 relock flag", v, 4);
    wr(2, 0);
    rd(2, v); chk("R11 zero no effect", v, 4);
    chk("R13 irq lock", irq, 1);

    // random phase
    for (int it = 0; it < 400; it++) begin
      int op, m;
      op = $urandom % 8;
      m = $urandom % 4;
      case (op)
        0: wr(8 + 4 * m, pick_w());
        1: wr(9 + 4 * m, pick_h());
        2: wr(10 + 4 * m, $urandom % 2);
        3: wr(11 + 4 * m, ($urandom % 4) != 0);
        4: wr(3, $urandom % 2);
        5: if ($urandom % 2) meas(ac_w[m], ac_h[m], ac_i[m]);
           else meas(pick_w(), pick_h(), $urandom % 2);
        6: if ($urandom % 2) wr(2, $urandom % 8); else wr(0, $urandom % 8);
        default: sof($urandom % 2, $urandom % 2);
      endcase
      chk("R13 irq random", irq, |(exp_fl & exp_en));
      chk("R10 locked random", gen_locked, m_locked);
      chk_reg("R3 R8 match random", 1);
      chk_reg("R9 R11 flags random", 2);
      if (op <= 4) chk_reg("R4 R6 readback random", 8 + 4 * m + ($urandom % 4));
      chk_outputs("R7 outputs random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule